// File: doc/BRIEF.md
# Multi-Ratio Synchronized Pulse Divider

This block counts rising edges of a slow pulse stream and drives seven divided outputs at once, one for each ratio from 2 to 8. Each output is high for one period of the incoming pulse stream out of every N. All seven dividers start together from one restart input that acts only on its rising edge, so the outputs keep fixed phase families: /2, /4 and /8 line up, and so do /3 and /6. A level-sensitive hold input stops all counting and drives every output high for as long as it stays asserted.

The pulse, restart and hold inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer. The pulse and restart inputs also pass through a rising-edge detector. A small controller state machine turns the synchronized events into one command per cycle, and that command goes to all seven modulo-N counters. There are three states. ARMED: all outputs are forced high after a restart, until the next counted pulse. RUN: normal counting. HOLD: frozen, all outputs high. The named transitions are:

- restart-arm: RUN or HOLD to ARMED on a restart edge.
- re-arm: ARMED to ARMED on another restart edge.
- first-step: ARMED to RUN on a counted pulse.
- freeze: any state to HOLD while hold is high.
- thaw: HOLD to RUN when hold drops with no restart edge.

A restart counts as the first step of every divider. Because of this, wiring the /8 output back to restart makes the whole divider repeat every 7 pulses.

Top module: `pulse_ratio_divider`

## Requirements
- R1: With hold low and no restart edge, output bit i (ratio i+2) is high for exactly one pulse period out of every i+2 counted pulses. An output changes only in the cycle after a counted pulse, a restart edge or a synchronized hold level.
- R2: A rising edge on pulse_in that is first sampled at system clock edge m changes the outputs at edge m+2. The outputs stay unchanged after edges m and m+1.
- R3: div_o[2] (/4) is high only while div_o[0] (/2) is high. div_o[6] (/8) is high only while div_o[2] is high. div_o[4] (/6) is high only while div_o[1] (/3) is high.
- R4: A synchronized restart rising edge with hold low drives all outputs high until the next counted pulse. After that pulse, output i first rises again i+1 counted pulses after the restart, and then every i+2 pulses.
- R5: A restart input held high restarts the dividers only once, and counting then continues.
- R6: If a restart edge and a pulse edge are detected in the same cycle, the restart wins and that pulse is not counted.
- R7: While the synchronized hold is high, all outputs are high. Pulse edges and restart edges are ignored.
- R8: After hold is released, all outputs stay high until the next counted pulse. That pulse drives every output low, and output i rises again after i+2 counted pulses from the release.
- R9: With div_o[6] fed back to restart_in, and pulse periods of at least 5 system cycles, successive /8 rises are 7 counted pulses apart.
- R10: Following a restart, /6 and /7 are both high together 41 counted pulses later, and not at 42.
- R11: While rst_n is low, and directly after it is released, all outputs are high and the dividers are in the post-restart state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pulse_in | input | 1 | Asynchronous pulse stream to be divided; rising edges are counted |
| restart_in | input | 1 | Asynchronous restart; only its rising edge acts |
| hold_in | input | 1 | Asynchronous level; high freezes counting with all outputs high |
| div_o | output | 7 | Divided outputs; bit i divides by i+2 |

## Verification
The checker watches every cycle for the phase-family relations between /2, /4, /8 and /3, /6. It also checks that outputs are all high after a restart edge and under hold, that the output vector changes only after a pulse, restart or hold event, and that the first pulse after a hold release clears every output. The bench's behavioural model compares the outputs on every cycle through mixed streams with holds and restarts. The bench alone shows the things that span many cycles: the exact two-cycle synchronizer latency, the single restart from a level held high, the dropped pulse when pulse and restart coincide, the 41/42 coincidence of /6 and /7, and the 7-pulse period when /8 is fed back to restart.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,   // after restart: outputs forced high until next counted pulse
        ST_RUN   = 2'd1,   // normal counting
        ST_HOLD  = 2'd2    // frozen, outputs forced high
    } pdiv_state_e;

    // Command broadcast to every modulo-N counter
    typedef enum logic [1:0] {
        CMD_KEEP   = 2'd0,
        CMD_STEP   = 2'd1,
        CMD_PRESET = 2'd2,
        CMD_CLEAR  = 2'd3
    } pdiv_cmd_e;

endpackage

// File: rtl/pdiv_sync_edge.sv
module pdiv_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign level_o = chain_q[LAST];
    assign rise_o  = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl
    import pdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        restart_i,
    input  logic        hold_i,
    output pdiv_cmd_e   cmd_o,
    output logic        force_hi_o,
    output pdiv_state_e state_o
);
    pdiv_state_e state_q;
    pdiv_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;   // R11: reset equals post-restart state
        else        state_q <= state_d;
    end

    // Next-state logic: freeze > restart-arm > first-step / thaw
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (hold_i)         state_d = ST_HOLD;   // freeze
                else if (restart_i) state_d = ST_ARMED;  // re-arm
                else if (tick_i)    state_d = ST_RUN;    // first-step
            end
            ST_RUN: begin
                if (hold_i)         state_d = ST_HOLD;   // freeze
                else if (restart_i) state_d = ST_ARMED;  // restart-arm
            end
            ST_HOLD: begin
                if (hold_i)         state_d = ST_HOLD;
                else if (restart_i) state_d = ST_ARMED;  // restart-arm
                else                state_d = ST_RUN;    // thaw
            end
            default:                state_d = ST_ARMED;
        endcase
    end

    // Outputs: counter command (R6: restart beats a same-cycle pulse; R7: hold beats both)
    always_comb begin
        if (hold_i)         cmd_o = CMD_CLEAR;
        else if (restart_i) cmd_o = CMD_PRESET;
        else if (tick_i)    cmd_o = CMD_STEP;
        else                cmd_o = CMD_KEEP;
        force_hi_o = (state_q != ST_RUN);
        state_o    = state_q;
    end

endmodule

// File: rtl/pdiv_modn_counter.sv
module pdiv_modn_counter
    import pdiv_pkg::*;
#(
    parameter int RATIO = 2,
    parameter int CW    = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pdiv_cmd_e cmd_i,
    output logic      zero_o
);
    // A restart counts as the first step of each divider (R4, R9)
    localparam logic [CW-1:0] PRESET_VAL = CW'(1 % RATIO);
    localparam logic [CW-1:0] LAST_VAL   = CW'(RATIO - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= PRESET_VAL;
        end else begin
            unique case (cmd_i)
                CMD_KEEP:   count_q <= count_q;
                CMD_STEP:   count_q <= (count_q == LAST_VAL) ? '0 : count_q + 1'b1;
                CMD_PRESET: count_q <= PRESET_VAL;
                CMD_CLEAR:  count_q <= '0;
                default:    count_q <= count_q;
            endcase
        end
    end

    assign zero_o = (count_q == '0);

endmodule

// File: rtl/pulse_ratio_divider.sv
module pulse_ratio_divider
    import pdiv_pkg::*;
#(
    parameter int MIN_RATIO   = 2,
    parameter int NUM_OUT     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pulse_in,
    input  logic               restart_in,
    input  logic               hold_in,
    output logic [NUM_OUT-1:0] div_o
);
    localparam int MAX_RATIO = MIN_RATIO + NUM_OUT - 1;
    localparam int CW        = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

    logic        tick_w;
    logic        restart_w;
    logic        hold_w;
    logic        pulse_lvl_w;
    logic        restart_lvl_w;
    logic        hold_rise_w;
    logic        force_hi_w;
    pdiv_cmd_e   cmd_w;
    pdiv_state_e state_w;
    logic [NUM_OUT-1:0] zero_w;

    // R2: two-flop synchronizers with edge detect
    pdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_pulse (
        .clk(clk), .rst_n(rst_n), .d_i(pulse_in),
        .level_o(pulse_lvl_w), .rise_o(tick_w)
    );

    pdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_restart (
        .clk(clk), .rst_n(rst_n), .d_i(restart_in),
        .level_o(restart_lvl_w), .rise_o(restart_w)
    );

    pdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_hold (
        .clk(clk), .rst_n(rst_n), .d_i(hold_in),
        .level_o(hold_w), .rise_o(hold_rise_w)
    );

    pdiv_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick_w), .restart_i(restart_w), .hold_i(hold_w),
        .cmd_o(cmd_w), .force_hi_o(force_hi_w), .state_o(state_w)
    );

    // R1: one modulo-N counter per ratio
    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
            pdiv_modn_counter #(.RATIO(MIN_RATIO + g), .CW(CW)) u_cnt (
                .clk(clk), .rst_n(rst_n), .cmd_i(cmd_w), .zero_o(zero_w[g])
            );
            assign div_o[g] = zero_w[g] | force_hi_w;
        end
    endgenerate

endmodule

// File: rtl/pulse_ratio_divider_chk.sv
module pulse_ratio_divider_chk
    import pdiv_pkg::*;
#(
    parameter int MIN_RATIO = 2,
    parameter int NUM_OUT   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] div_o,
    input  logic               tick,
    input  logic               restart,
    input  logic               hold,
    input  pdiv_state_e        state
);
    generate
        if (MIN_RATIO == 2 && NUM_OUT >= 7) begin : g_family
            assert_fam_div4_R3: assert property (@(posedge clk) disable iff (!rst_n)
                div_o[2] |-> div_o[0]);
            assert_fam_div8_R3: assert property (@(posedge clk) disable iff (!rst_n)
                div_o[6] |-> div_o[2]);
            assert_fam_div6_R3: assert property (@(posedge clk) disable iff (!rst_n)
                div_o[4] |-> div_o[1]);
        end
    endgenerate

    assert_restart_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !hold) |=> (&div_o));

    assert_restart_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && tick && !hold) |=> (&div_o));

    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (&div_o));

    assert_thaw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hold && tick && !restart) |=> (div_o == '0));

    assert_change_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_o) |-> $past(tick || restart || hold));

endmodule

bind pulse_ratio_divider pulse_ratio_divider_chk #(
    .MIN_RATIO(MIN_RATIO),
    .NUM_OUT(NUM_OUT)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .div_o(div_o),
    .tick(tick_w),
    .restart(restart_w),
    .hold(hold_w),
    .state(state_w)
);

// File: tb/pulse_ratio_divider_tb_top.sv
module pulse_ratio_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NOUT       = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0;
    logic restart_drv = 1'b0;
    logic hold_in = 1'b0;
    logic fb_mode = 1'b0;
    logic fb_q = 1'b0;
    logic restart_in;
    logic [NOUT-1:0] div_o;

    assign restart_in = fb_mode ? fb_q : restart_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_ratio_divider dut_i (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .restart_in(restart_in), .hold_in(hold_in), .div_o(div_o)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    int  issued = 0;
    bit  done = 0;
    int  rise_q[$];
    logic prev6 = 1'b1;

    // Behavioural reference: input history, integer counters
    bit p1, p2, p3, r1, r2, r3, h1, h2;
    int mcnt [NOUT];
    bit marm;
    logic [NOUT-1:0] mexp;

    function automatic logic [NOUT-1:0] model_out();
        logic [NOUT-1:0] v;
        for (int i = 0; i < NOUT; i++) v[i] = marm || (mcnt[i] == 0);
        return v;
    endfunction

    task automatic model_reset();
        {p1, p2, p3, r1, r2, r3, h1, h2} = '0;
        for (int i = 0; i < NOUT; i++) mcnt[i] = 1 % (i + 2);
        marm = 1'b1;
        mexp = model_out();
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit tk, rr, hl;
            tk = p2 && !p3;
            rr = r2 && !r3;
            hl = h2;
            if (hl) begin
                for (int i = 0; i < NOUT; i++) mcnt[i] = 0;
                marm = 1'b0;
            end else if (rr) begin
                for (int i = 0; i < NOUT; i++) mcnt[i] = 1 % (i + 2);
                marm = 1'b1;
            end else if (tk) begin
                for (int i = 0; i < NOUT; i++) mcnt[i] = (mcnt[i] + 1) % (i + 2);
                marm = 1'b0;
            end
            p3 = p2; p2 = p1; p1 = pulse_in;
            r3 = r2; r2 = r1; r1 = restart_in;
            h2 = h1; h1 = hold_in;
            mexp = model_out();
        end
    end

    task automatic check(string tag, logic [NOUT-1:0] got, logic [NOUT-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_int(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Every-cycle comparison against the model and the family relations
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 model compare", div_o, mexp);
            check("R3 family /4 within /2", {6'b0, div_o[2] && !div_o[0]}, '0);
            check("R3 family /8 within /4", {6'b0, div_o[6] && !div_o[2]}, '0);
            check("R3 family /6 within /3", {6'b0, div_o[4] && !div_o[1]}, '0);
        end
        if (fb_mode && div_o[6] && !prev6) rise_q.push_back(issued);
        prev6 = div_o[6];
        fb_q <= div_o[6];
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_pulse(int hi, int lo);
        issued++;
        pulse_in = 1'b1;
        wait_cyc(hi);
        pulse_in = 1'b0;
        wait_cyc(lo);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        check("R11 outputs high in reset", div_o, 7'h7F);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R11 outputs high after reset", div_o, 7'h7F);

        // R4 / R10: restart then 42 pulses
        restart_drv = 1'b1; wait_cyc(2); restart_drv = 1'b0; wait_cyc(4);
        check("R4 all high after restart", div_o, 7'h7F);
        for (int k = 1; k <= 42; k++) begin
            give_pulse(2, 4);
            if (k == 1)  check("R4 first pulse after restart", div_o, 7'h01);
            if (k == 7)  check("R4 /8 rises after 7 pulses", {6'b0, div_o[6]}, 7'h01);
            if (k == 41) check("R10 /6 and /7 coincide", {6'b0, div_o[4] & div_o[5]}, 7'h01);
            if (k == 42) check("R10 no coincidence at 42", div_o, 7'h00);
        end

        // R5: restart held high acts once
        restart_drv = 1'b1; wait_cyc(4);
        check("R5 restart level high", div_o, 7'h7F);
        for (int k = 0; k < 3; k++) give_pulse(2, 4);
        check("R5 counting continues with restart high", div_o, 7'b0000101);
        restart_drv = 1'b0; wait_cyc(4);

        // R6: coincident restart and pulse
        pulse_in = 1'b1; restart_drv = 1'b1; issued++;
        wait_cyc(2);
        pulse_in = 1'b0; restart_drv = 1'b0;
        wait_cyc(4);
        check("R6 coincident pulse dropped", div_o, 7'h7F);
        give_pulse(2, 4);
        check("R6 next pulse is first step", div_o, 7'h01);

        // R7: hold freezes with all outputs high
        hold_in = 1'b1; wait_cyc(4);
        check("R7 hold forces high", div_o, 7'h7F);
        for (int k = 0; k < 3; k++) give_pulse(2, 4);
        restart_drv = 1'b1; wait_cyc(2); restart_drv = 1'b0; wait_cyc(4);
        check("R7 pulses and restart ignored in hold", div_o, 7'h7F);

        // R8 / R2: release, then exact latency of the first pulse
        hold_in = 1'b0; wait_cyc(4);
        check("R8 high after release", div_o, 7'h7F);
        pulse_in = 1'b1; issued++;
        @(negedge clk);
        check("R2 no change after sampling edge", div_o, 7'h7F);
        @(negedge clk);
        check("R2 no change one edge later", div_o, 7'h7F);
        @(negedge clk);
        check("R2 R8 change two edges after sampling", div_o, 7'h00);
        pulse_in = 1'b0; wait_cyc(3);
        give_pulse(2, 4);
        check("R8 /2 after two pulses from release", div_o, 7'h01);

        // R1: mixed stream with occasional holds and restarts
        for (int k = 0; k < 240; k++) begin
            if (k % 29 == 13) begin
                hold_in = 1'b1; wait_cyc(3);
                give_pulse(1, 1);
                hold_in = 1'b0; wait_cyc(2 + k % 3);
            end else if (k % 23 == 7) begin
                restart_drv = 1'b1; wait_cyc(1 + k % 3); restart_drv = 1'b0;
            end
            give_pulse(1 + k % 3, 1 + k % 4);
        end

        // R9: /8 fed back to restart
        wait_cyc(4);
        fb_mode = 1'b1;
        wait_cyc(6);
        for (int k = 0; k < 40; k++) give_pulse(2, 4);
        check_int("R9 enough /8 rises", (rise_q.size() >= 3) ? 1 : 0, 1);
        if (rise_q.size() >= 3) begin
            check_int("R9 feedback period", rise_q[rise_q.size()-1] - rise_q[rise_q.size()-2], 7);
            check_int("R9 feedback period prior", rise_q[rise_q.size()-2] - rise_q[rise_q.size()-3], 7);
        end
        fb_mode = 1'b0;
        wait_cyc(4);

        done = 1;
        summary();
        $finish;
    end

endmodule